// File: doc/BRIEF.md
# Dual-Bank Burst Read Sequencer

This block is the clocked burst-read front end of a 2M x 16 memory split into a low bank and a high bank. A host places a start address on the address pins and pulls chip enable and address-valid low across one rising clock edge. From then on, an internal counter steps once per clock, and the block returns one 16-bit word per clock, starting two clocks after the capture. The counter runs straight from the low bank into the high bank. After the top of memory it goes back to address zero. No bank edge limits the burst length.

Either bank can be busy with a program or erase job, which is flagged by a per-bank busy input. Any word whose address falls in a busy bank is replaced by the status word. The counter keeps advancing. When the burst leaves the busy bank, array data returns. The array is modelled as fixed, computed contents. Program and erase themselves are not part of this block, and neither is wait signalling or asynchronous reads.

The output side is a stream with a valid flag and no ready. A word is valid for exactly one clock. There is no back-pressure: the consumer must take every word while `rd_valid` is high, and words fetched while output-enable is high are lost. The data bus floats whenever chip enable or output-enable is high.

Top module: `dbank_burst_rd`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), no burst is active and `rd_valid` is low. After reset, with `oe_n` high, `dq` is high-impedance.
- R2: The start address is loaded into the counter on a rising edge only when `ce_n` and `adv_n` are both low at that edge.
- R3: During a burst the counter advances by exactly one on every clock, and consecutive valid words carry consecutive addresses on `cur_addr`.
- R4: The array word at address A is A[15:0] XOR {A[20:16], 11'b0}.
- R5: The low bank covers 000000h–07FFFFh and the high bank covers 080000h–1FFFFFh. A burst passes from 07FFFFh to 080000h with no gap.
- R6: After 1FFFFFh the counter continues at 000000h with no gap.
- R7: A word whose address lies in a bank whose busy flag is high when that word is fetched reads as `stat_word`. The counter still advances, and array words resume once the address leaves that bank.
- R8: The first word is valid on the second rising edge after the capture edge, and later words follow on consecutive edges. A new capture during a burst drops the words in flight and restarts this latency.
- R9: `dq` is high-impedance and `rd_valid` is low whenever `ce_n` or `oe_n` is high. `oe_n` does not pause the counter.
- R10: `ce_n` high at a rising edge ends the burst. With `ce_n` low again but no new capture, no word becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 21 | Burst start address |
| busy_lo | input | 1 | Low bank is programming or erasing |
| busy_hi | input | 1 | High bank is programming or erasing |
| stat_word | input | 16 | Status word returned for busy banks |
| dq | output | 16 | Data bus, high-impedance when not enabled |
| rd_valid | output | 1 | Word on `dq` is valid this cycle |
| cur_addr | output | 21 | Address of the word on `dq` |

## Verification
Bursts are started in the middle of the low bank, just below the bank edge and just below the top of memory. This separates plain counting from the seam crossing and from the wrap back to zero. The busy flags are raised for the bank being entered, for the bank a burst starts in, and for the high bank during a wrap. These runs show whether substitution follows the address of each word rather than the bank the burst started in. A second capture mid-burst, a stretch with output-enable high, and a chip-enable break show the restart latency, show that the counter keeps running while the bus floats, and show that a burst ends without a fresh capture.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;
endpackage

// File: rtl/dbr_counter.sv
module dbr_counter #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] ctr_q,
  output logic          active_q,
  output logic          load,
  output logic          step
);
  localparam logic [AW-1:0] ONE = AW'(1);

  assign load = !ce_n && !adv_n;
  assign step = !ce_n && adv_n && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q    <= '0;
      active_q <= 1'b0;
    end else if (ce_n) begin
      active_q <= 1'b0;
    end else if (load) begin
      ctr_q    <= addr;
      active_q <= 1'b1;
    end else if (step) begin
      ctr_q <= ctr_q + ONE; // natural wrap at top of memory
    end
  end
endmodule

// File: rtl/dbr_fetch.sv
module dbr_fetch
  import dbr_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter logic [AW-1:0] SPLIT = 21'h080000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          step,
  input  logic [AW-1:0] ctr,
  input  logic          busy_lo,
  input  logic          busy_hi,
  input  logic [DW-1:0] stat_word,
  output logic          f_valid,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_data
);
  localparam int HW = AW - DW;  // high address bits folded into the word
  localparam int SH = DW - HW;

  bank_e         bank;
  logic          bank_busy;
  logic [DW-1:0] arr_word;
  logic [DW-1:0] hi_part;

  assign bank      = (ctr >= SPLIT) ? BANK_HI : BANK_LO;
  assign bank_busy = (bank == BANK_HI) ? busy_hi : busy_lo;

  generate
    if (HW > 0) begin : g_fold
      assign hi_part = DW'(ctr[AW-1:DW]) << SH;
    end else begin : g_nofold
      assign hi_part = '0;
    end
  endgenerate

  assign arr_word = ctr[DW-1:0] ^ hi_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_valid <= 1'b0;
      f_addr  <= '0;
      f_data  <= '0;
    end else if (flush) begin
      f_valid <= 1'b0;
    end else begin
      f_valid <= step;
      if (step) begin
        f_addr <= ctr;
        f_data <= bank_busy ? stat_word : arr_word;
      end
    end
  end
endmodule

// File: rtl/dbr_drive.sv
module dbr_drive #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          ce_n,
  input  logic          oe_n,
  output logic          o_valid,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] dq,
  output logic          rd_valid
);
  logic [DW-1:0] o_data;
  logic          drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_addr  <= '0;
      o_data  <= '0;
    end else if (flush) begin
      o_valid <= 1'b0;
    end else begin
      o_valid <= in_valid;
      if (in_valid) begin
        o_addr <= in_addr;
        o_data <= in_data;
      end
    end
  end

  assign drive    = !ce_n && !oe_n;
  assign rd_valid = drive && o_valid;
  assign dq       = drive ? o_data : {DW{1'bz}};
endmodule

// File: rtl/dbank_burst_rd.sv
module dbank_burst_rd #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter logic [AW-1:0] SPLIT = 21'h080000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          busy_lo,
  input  logic          busy_hi,
  input  logic [DW-1:0] stat_word,
  output logic [DW-1:0] dq,
  output logic          rd_valid,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] ctr_q;
  logic          active_q;
  logic          load;
  logic          step;
  logic          flush;
  logic          f_valid;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data;
  logic          o_valid;

  assign flush = ce_n || load;

  dbr_counter #(.AW(AW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .ctr_q(ctr_q), .active_q(active_q), .load(load), .step(step)
  );

  dbr_fetch #(.AW(AW), .DW(DW), .SPLIT(SPLIT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .step(step), .ctr(ctr_q),
    .busy_lo(busy_lo), .busy_hi(busy_hi), .stat_word(stat_word),
    .f_valid(f_valid), .f_addr(f_addr), .f_data(f_data)
  );

  dbr_drive #(.AW(AW), .DW(DW)) u_drv (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(f_valid),
    .in_addr(f_addr), .in_data(f_data), .ce_n(ce_n), .oe_n(oe_n),
    .o_valid(o_valid), .o_addr(cur_addr), .dq(dq), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          adv_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] ctr_q,
  input logic          active_q,
  input logic          o_valid,
  input logic          rd_valid,
  input logic [AW-1:0] cur_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n) |=> (ctr_q == $past(addr))); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && adv_n && active_q) |=> (ctr_q == $past(ctr_q) + ONE)); // R3

  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n) |=> !o_valid); // R8

  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && $past(o_valid)) |-> (cur_addr == $past(cur_addr) + ONE)); // R6

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !rd_valid); // R9

  AST_CE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!o_valid && !active_q)); // R10
endmodule

bind dbank_burst_rd dbr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
  .addr(addr), .ctr_q(ctr_q), .active_q(active_q), .o_valid(o_valid),
  .rd_valid(rd_valid), .cur_addr(cur_addr)
);

// File: tb/test_dbank_burst_rd.sv
module test_dbank_burst_rd;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, adv_n, oe_n;
  logic [20:0] addr;
  logic        busy_lo, busy_hi;
  logic [15:0] stat_word;
  logic [15:0] dq;
  logic        rd_valid;
  logic [20:0] cur_addr;

  int checks = 0;
  int errors = 0;

  dbank_burst_rd i_dbank_burst_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .addr(addr), .busy_lo(busy_lo), .busy_hi(busy_hi), .stat_word(stat_word),
    .dq(dq), .rd_valid(rd_valid), .cur_addr(cur_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] arr_word(input logic [20:0] a);
    return a[15:0] ^ {a[20:16], 11'b0};  // R4
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: one word in flight, one word on the bus.
  bit          m_act;
  int          m_ctr;
  bit          p_v, e_v;
  int          p_a, e_a;
  logic [15:0] p_d, e_d;
  string       p_tag, e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ctr = 0; p_v = 0; e_v = 0;
    end else begin
      bit cap;
      cap = !ce_n && !adv_n;
      if (ce_n || cap) begin
        e_v = 0;
        p_v = 0;
      end else begin
        e_v = p_v; e_a = p_a; e_d = p_d; e_tag = p_tag;
        p_v = m_act;
        if (m_act) begin
          bit hi;
          hi  = m_ctr >= 'h80000;
          p_a = m_ctr;
          if ((hi && busy_hi) || (!hi && busy_lo)) begin
            p_d = stat_word; p_tag = "R7";
          end else begin
            p_d = arr_word(21'(m_ctr));
            p_tag = (m_ctr == 'h80000) ? "R5" : (m_ctr == 0) ? "R6" : "R4";
          end
          m_ctr = (m_ctr + 1) % (1 << 21);
        end
      end
      if (ce_n) m_act = 0;
      else if (cap) begin m_act = 1; m_ctr = int'(addr); end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (e_v && !ce_n && !oe_n) begin
        chk("R8", 32'(rd_valid), 32'd1);
        chk(e_tag, 32'(dq), 32'(e_d));
        chk("R3", 32'(cur_addr), 32'(e_a));
      end else begin
        chk((ce_n || oe_n) ? "R9" : (!m_act ? "R10" : "R8"), 32'(rd_valid), 32'd0);
        if (ce_n || oe_n) begin
          checks++;
          if (dq !== 16'hzzzz) begin
            errors++;
            $display("FAIL R9: actual=%h expected=zzzz at %0t", dq, $time);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start(input logic [20:0] a);
    ce_n = 0; adv_n = 0; addr = a;
    tick(1);
    adv_n = 1; addr = 21'h15555;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; ce_n = 1; adv_n = 1; oe_n = 1; addr = '0;
    busy_lo = 0; busy_hi = 0; stat_word = 16'h0080;
    tick(3);
    chk("R1", 32'(rd_valid), 32'd0);
    rst_n = 1;
    tick(1);
    checks++;
    if (dq !== 16'hzzzz) begin
      errors++;
      $display("FAIL R1: actual=%h expected=zzzz", dq);
    end
    oe_n = 0;
    // plain burst mid low bank
    start(21'h00100); tick(8);
    // seam crossing
    start(21'h7FFFC); tick(8);
    // wrap at top of memory
    start(21'h1FFFFD); tick(7);
    // entering busy high bank, then wrap to idle low bank
    busy_hi = 1; stat_word = 16'h00C3;
    start(21'h7FFFE); tick(6);
    start(21'h1FFFFE); tick(6);
    busy_hi = 0;
    // start inside busy low bank and leave it
    busy_lo = 1; stat_word = 16'h0081;
    start(21'h7FFFD); tick(6);
    busy_lo = 0;
    // restart mid-burst
    start(21'h01230); tick(3);
    start(21'h1A000); tick(5);
    // OE high does not pause the counter
    oe_n = 1; tick(3); oe_n = 0; tick(4);
    // CE break ends the burst
    ce_n = 1; tick(2); ce_n = 0; tick(5);
    ce_n = 1; tick(2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule